// File: doc/BRIEF.md
# Code Word and Seed Format Selector

This block assembles the 69-bit word that a code hopping encoder sends, and decides for each word whether it carries the normal payload or the stored seed. A normal word holds the 32 hopping bits from the cipher and the 32-bit serial field. In a seed word, the 60 low payload bits are replaced by a seed value stored at manufacture. Both formats put the 4-bit nibble slot and the 5-bit status tail (low-voltage status, CRC and the remaining status bits, produced outside) at the same positions.

Seed permission has three modes, taken from two configuration bits. Seeds can be always refused, always allowed, or allowed only for a limited time. The limited permission ends for good on the first synchronization counter increment that takes the counter's low 7 bits from 7Fh to 00h. After that, only a configuration reload pulse grants it again. A second configuration bit chooses a full 32-bit serial number, or a 28-bit serial number whose top nibble carries the button status. The word and the format flag are registered on a build strobe.

Top module: `codeword_sel`

## Requirements
- R1: With `cfg_ser32_i`=1 and a normal word, `word_o[31:0]` equals `hop_i`, `word_o[59:32]` equals `serial_i[27:0]` and `word_o[63:60]` equals `serial_i[31:28]`.
- R2: With `cfg_ser32_i`=0, `word_o[63:60]` equals `btn_i` instead of `serial_i[31:28]`, in both formats.
- R3: `word_o[68:64]` equals `tail_i` in both formats.
- R4: When a seed word is sent, `word_o[59:0]` equals `seed_i` and `seed_sel_o` is 1. In every other word `seed_sel_o` is 0.
- R5: With `cfg_seed_en_i`=0, seeds are refused: a build with `seed_req_i`=1 gives a normal word with `seed_sel_o`=0.
- R6: With `cfg_seed_en_i`=1 and `cfg_seed_tmp_i`=0, every requested seed is granted, whether or not the counter has wrapped.
- R7: With `cfg_seed_en_i`=1 and `cfg_seed_tmp_i`=1, seeds are granted until a cycle in which `cnt_inc_i`=1 and `cnt_lo_i`=7Fh. From the next cycle on, requests give normal words.
- R8: Expiry is sticky. An increment at any other counter value, or `cnt_lo_i`=7Fh without `cnt_inc_i`, does not expire the permission. Changing the mode bits does not clear it. Only a `cfg_reload_i` pulse clears it, and a reload wins over a wrap in the same cycle.
- R9: Outputs update on the clock edge where `build_i`=1. Otherwise they hold their value.
- R10: Reset clears `word_o` to 0, `seed_sel_o` to 0 and the expiry state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| build_i | input | 1 | Capture a new word on this edge |
| seed_req_i | input | 1 | Ask for a seed word |
| hop_i | input | 32 | Hopping data from the cipher |
| serial_i | input | 32 | Serial number field |
| btn_i | input | 4 | Button status |
| seed_i | input | 60 | Stored seed value |
| tail_i | input | 5 | Status tail (low-voltage, CRC, remaining bits) |
| cfg_ser32_i | input | 1 | 1: 32-bit serial, 0: 28-bit serial plus buttons |
| cfg_seed_en_i | input | 1 | Seed permission enable |
| cfg_seed_tmp_i | input | 1 | Limited seed permission when enabled |
| cfg_reload_i | input | 1 | Configuration reload pulse, re-arms limited permission |
| cnt_lo_i | input | 7 | Low bits of the synchronization counter |
| cnt_inc_i | input | 1 | Counter increment strobe |
| word_o | output | 69 | Assembled word |
| seed_sel_o | output | 1 | 1 when word_o is a seed word |

## Verification
The hardest state to reach is the expired limited permission. Only the one increment that leaves 7Fh reaches it, and once reached it hides behind the mode bits. The stimulus first sends increments at 7Eh and a bare 7Fh value without the strobe, and confirms seeds are still granted. It then sends the wrapping increment and confirms the refusal. It toggles into the always-allowed mode and back, to show that the expiry survives, and then clears it with a reload that lands in the same cycle as a second wrap.

// File: rtl/cwsel_pkg.sv
package cwsel_pkg;
  typedef enum logic [1:0] {
    SEED_OFF    = 2'd0,
    SEED_ALWAYS = 2'd1,
    SEED_TEMP   = 2'd2
  } seed_mode_e;

  function automatic seed_mode_e decode_mode(input logic en, input logic tmp);
    if (!en)     return SEED_OFF;
    else if (tmp) return SEED_TEMP;
    else          return SEED_ALWAYS;
  endfunction
endpackage

// File: rtl/cwsel_rst_sync.sv
module cwsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cwsel_seed_gate.sv
module cwsel_seed_gate
  import cwsel_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seed_mode_e       mode,
  input  logic             reload,
  input  logic [CNT_W-1:0] cnt_lo,
  input  logic             cnt_inc,
  output logic             grant
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic expired_q, expired_d, wrap;

  assign wrap = cnt_inc && (cnt_lo == CNT_TOP);

  always_comb begin
    expired_d = expired_q;
    if (reload)                         expired_d = 1'b0;
    else if (mode == SEED_TEMP && wrap) expired_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) expired_q <= 1'b0;
    else        expired_q <= expired_d;
  end

  always_comb begin
    unique case (mode)
      SEED_ALWAYS: grant = 1'b1;
      SEED_TEMP:   grant = !expired_q;
      default:     grant = 1'b0;
    endcase
  end

  // R8: expiry stays set until a reload
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_q && !reload) |=> expired_q);

  // R7: a wrap in limited mode expires the permission
  a_r7_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEED_TEMP && wrap && !reload) |=> (mode != SEED_TEMP || !grant));
endmodule

// File: rtl/cwsel_assemble.sv
module cwsel_assemble #(
  parameter int HOP_W  = 32,
  parameter int SER_W  = 32,
  parameter int BTN_W  = 4,
  parameter int TAIL_W = 5,
  localparam int SEED_W = HOP_W + SER_W - BTN_W,
  localparam int WORD_W = HOP_W + SER_W + TAIL_W
) (
  input  logic [HOP_W-1:0]  hop,
  input  logic [SER_W-1:0]  serial,
  input  logic [BTN_W-1:0]  btn,
  input  logic [SEED_W-1:0] seed,
  input  logic [TAIL_W-1:0] tail,
  input  logic              ser_full,
  input  logic              use_seed,
  output logic [WORD_W-1:0] word
);
  localparam int LOW_SER_W = SER_W - BTN_W;

  logic [SEED_W-1:0] payload;
  logic [BTN_W-1:0]  nibble;

  always_comb begin
    payload = use_seed ? seed : {serial[LOW_SER_W-1:0], hop};
    nibble  = ser_full ? serial[SER_W-1:LOW_SER_W] : btn;
    word    = {tail, nibble, payload};
  end
endmodule

// File: rtl/codeword_sel.sv
module codeword_sel
  import cwsel_pkg::*;
#(
  parameter int HOP_W  = 32,
  parameter int SER_W  = 32,
  parameter int BTN_W  = 4,
  parameter int TAIL_W = 5,
  parameter int CNT_W  = 7,
  localparam int SEED_W = HOP_W + SER_W - BTN_W,
  localparam int WORD_W = HOP_W + SER_W + TAIL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              build_i,
  input  logic              seed_req_i,
  input  logic [HOP_W-1:0]  hop_i,
  input  logic [SER_W-1:0]  serial_i,
  input  logic [BTN_W-1:0]  btn_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic [TAIL_W-1:0] tail_i,
  input  logic              cfg_ser32_i,
  input  logic              cfg_seed_en_i,
  input  logic              cfg_seed_tmp_i,
  input  logic              cfg_reload_i,
  input  logic [CNT_W-1:0]  cnt_lo_i,
  input  logic              cnt_inc_i,
  output logic [WORD_W-1:0] word_o,
  output logic              seed_sel_o
);
  logic              rst_n_s;
  seed_mode_e        mode;
  logic              grant, use_seed;
  logic [WORD_W-1:0] asm_word;
  logic [WORD_W-1:0] word_q, word_d;
  logic              sel_q, sel_d;

  cwsel_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign mode = decode_mode(cfg_seed_en_i, cfg_seed_tmp_i);

  cwsel_seed_gate #(.CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst_n(rst_n_s), .mode(mode), .reload(cfg_reload_i),
    .cnt_lo(cnt_lo_i), .cnt_inc(cnt_inc_i), .grant(grant)
  );

  assign use_seed = seed_req_i && grant;

  cwsel_assemble #(.HOP_W(HOP_W), .SER_W(SER_W), .BTN_W(BTN_W), .TAIL_W(TAIL_W)) u_asm (
    .hop(hop_i), .serial(serial_i), .btn(btn_i), .seed(seed_i), .tail(tail_i),
    .ser_full(cfg_ser32_i), .use_seed(use_seed), .word(asm_word)
  );

  always_comb begin
    word_d = word_q;
    sel_d  = sel_q;
    if (build_i) begin
      word_d = asm_word;
      sel_d  = use_seed;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      word_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      sel_q  <= sel_d;
    end
  end

  assign word_o     = word_q;
  assign seed_sel_o = sel_q;

  // R9: outputs hold without a build strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !build_i |=> ($stable(word_o) && $stable(seed_sel_o)));

  // R5: disabled permission never yields a seed word
  a_r5_off: assert property (@(posedge clk) disable iff (!rst_n_s)
    (build_i && !cfg_seed_en_i) |=> !seed_sel_o);

  // R3: status tail passes through in both formats
  a_r3_tail: assert property (@(posedge clk) disable iff (!rst_n_s)
    build_i |=> (word_o[WORD_W-1 -: TAIL_W] == $past(tail_i)));

  // R4: a seed word carries the stored seed
  a_r4_seed: assert property (@(posedge clk) disable iff (!rst_n_s)
    (build_i && seed_req_i) |=> (!seed_sel_o || word_o[SEED_W-1:0] == $past(seed_i)));
endmodule

// File: tb/sim_codeword_sel.sv
module sim_codeword_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        build_i, seed_req_i;
  logic [31:0] hop_i, serial_i;
  logic [3:0]  btn_i;
  logic [59:0] seed_i;
  logic [4:0]  tail_i;
  logic        cfg_ser32_i, cfg_seed_en_i, cfg_seed_tmp_i, cfg_reload_i;
  logic [6:0]  cnt_lo_i;
  logic        cnt_inc_i;
  logic [68:0] word_o;
  logic        seed_sel_o;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  codeword_sel u0 (
    .clk(clk), .rst_n(rst_n), .build_i(build_i), .seed_req_i(seed_req_i),
    .hop_i(hop_i), .serial_i(serial_i), .btn_i(btn_i), .seed_i(seed_i), .tail_i(tail_i),
    .cfg_ser32_i(cfg_ser32_i), .cfg_seed_en_i(cfg_seed_en_i), .cfg_seed_tmp_i(cfg_seed_tmp_i),
    .cfg_reload_i(cfg_reload_i), .cnt_lo_i(cnt_lo_i), .cnt_inc_i(cnt_inc_i),
    .word_o(word_o), .seed_sel_o(seed_sel_o)
  );

  // {ser32, en, tmp, req, btn[3:0], tail[4:0], expected seed flag}
  localparam logic [13:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 4'h3, 5'h05, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b1, 4'h9, 5'h1A, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b1, 4'hC, 5'h11, 1'b1},
    {1'b0, 1'b1, 1'b0, 1'b1, 4'h6, 5'h0F, 1'b1},
    {1'b0, 1'b1, 1'b1, 1'b1, 4'hA, 5'h1F, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b0, 4'h5, 5'h00, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 5'h15, 1'b0},
    {1'b1, 1'b0, 1'b1, 1'b1, 4'h1, 5'h0A, 1'b0}
  };

  function automatic logic [68:0] model(input logic ser32, input logic sd,
      input logic [3:0] b, input logic [4:0] t, input logic [31:0] h,
      input logic [31:0] s, input logic [59:0] sv);
    logic [59:0] lo;
    logic [3:0]  nib;
    lo  = sd ? sv : {s[27:0], h};
    nib = ser32 ? s[31:28] : b;
    return {t, nib, lo};
  endfunction

  task automatic check(input string req, input logic [68:0] act, input logic [68:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build(input logic req);
    @(negedge clk);
    seed_req_i = req;
    build_i    = 1'b1;
    @(negedge clk);
    build_i    = 1'b0;
  endtask

  task automatic inc(input logic [6:0] c, input logic strobe, input logic rl);
    @(negedge clk);
    cnt_lo_i = c; cnt_inc_i = strobe; cfg_reload_i = rl;
    @(negedge clk);
    cnt_inc_i = 1'b0; cfg_reload_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_pattern(input int i);
    hop_i    = 32'hA5C3_0F10 ^ (32'h0101_0101 * i);
    serial_i = 32'h7E6D_5C4B + (32'h1111_1111 * i);
    seed_i   = 60'h0ED_CBA9_8765_4321 ^ 60'(i * 7919);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [68:0] held;
    build_i = 0; seed_req_i = 0; btn_i = 0; tail_i = 0;
    cfg_ser32_i = 1; cfg_seed_en_i = 0; cfg_seed_tmp_i = 0; cfg_reload_i = 0;
    cnt_lo_i = 0; cnt_inc_i = 0;
    set_pattern(0);
    do_reset();

    // R10: reset state
    check("R10 word", word_o, '0);
    check("R10 flag", {68'd0, seed_sel_o}, '0);

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      logic [13:0] v;
      v = VEC[i];
      set_pattern(i + 1);
      cfg_ser32_i = v[13]; cfg_seed_en_i = v[12]; cfg_seed_tmp_i = v[11];
      btn_i = v[9:6]; tail_i = v[5:1];
      build(v[10]);
      check("R1/R2/R3/R4 word", word_o,
            model(v[13], v[0], v[9:6], v[5:1], hop_i, serial_i, seed_i));
      check("R4/R5/R6/R7 flag", {68'd0, seed_sel_o}, {68'd0, v[0]});
    end

    // R9: no build, inputs change, output holds
    held = word_o;
    set_pattern(40); tail_i = 5'h0C; btn_i = 4'h2;
    repeat (3) @(negedge clk);
    check("R9 hold", word_o, held);

    // R7/R8: limited mode expiry corner cases
    cfg_ser32_i = 0; cfg_seed_en_i = 1; cfg_seed_tmp_i = 1;
    inc(7'h7E, 1'b1, 1'b0);
    inc(7'h7F, 1'b0, 1'b0);
    build(1'b1);
    check("R8 no early expiry", {68'd0, seed_sel_o}, 69'd1);
    inc(7'h7F, 1'b1, 1'b0);
    build(1'b1);
    check("R7 expired flag", {68'd0, seed_sel_o}, 69'd0);
    check("R7 expired word normal", word_o,
          model(1'b0, 1'b0, btn_i, tail_i, hop_i, serial_i, seed_i));
    // R6: always mode ignores expiry
    cfg_seed_tmp_i = 0;
    build(1'b1);
    check("R6 always grants", {68'd0, seed_sel_o}, 69'd1);
    // R8: back to limited, still expired
    cfg_seed_tmp_i = 1;
    build(1'b1);
    check("R8 sticky after mode toggle", {68'd0, seed_sel_o}, 69'd0);
    // R8: reload wins over simultaneous wrap
    inc(7'h7F, 1'b1, 1'b1);
    build(1'b1);
    check("R8 reload re-arms", {68'd0, seed_sel_o}, 69'd1);
    check("R4 seed payload", word_o,
          model(1'b0, 1'b1, btn_i, tail_i, hop_i, serial_i, seed_i));

    // R10: reset clears expiry
    inc(7'h7F, 1'b1, 1'b0);
    do_reset();
    check("R10 word after reset", word_o, '0);
    build(1'b1);
    check("R10 expiry cleared", {68'd0, seed_sel_o}, 69'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule